// File: doc/BRIEF.md
# Serial Block Write Engine with Status Retry

This block is the host half of a single-bit serial data line to a memory card, and it writes one data block per request. A start strobe means the card has just answered the write command. The engine then leaves the line idle for a fixed number of clocks and sends a framed block. The frame is a low start bit, the payload bytes read one by one from an external buffer, a 16-bit CRC and a high end bit. After that the engine releases the line and listens for the card's 3-bit status token.

If the card accepts the block, the engine waits until the card stops holding the line low for busy, then pulses `done`. A rejected token, or one that is malformed, makes the engine wait out the busy period and send the same block again, up to a set number of retransmissions. When the retries run out, or when no token starts within the timeout, the engine pulses `fail`. Away from its own frame the engine never drives the line. An external pull-up is assumed, so a released line reads high.

Top module: `serial_block_writer`

## Requirements
- R1: During and after reset the line is released (`dat_oe`=0), and `active`, `done` and `fail` are 0.
- R2: After `start` is sampled while idle, the line stays released for exactly N_WR clock periods. The next driven bit is the start bit, value 0.
- R3: The payload is `blk_len` bytes, sampled with `start`, taken from `byte_addr` 0 upward, each byte sent bit 7 first. A length of 0 sends no payload bits.
- R4: After the payload come 16 CRC bits, MSB first, then one end bit of 1. The CRC uses polynomial 0x1021 (x^16+x^12+x^5+1), starts at zero and covers only the payload bits. The line is driven from the start bit through the end bit and at no other time.
- R5: After the end bit the engine looks for a low token start bit during TOK_TIMEOUT clocks. If none arrives, `fail` pulses, `done` does not, and the block is not resent.
- R6: The status token is a 0 start bit, three status bits sent MSB first, and a 1 end bit. Only code 010 with a correct end bit is an acceptance.
- R7: Code 101, or any token with another code or a 0 end bit, causes the identical frame to be sent again.
- R8: After any token the engine waits while the line is low. It signals `done`, or starts a retransmission, only after the line reads high.
- R9: At most MAX_RETRY retransmissions follow the first frame. If the last one is also rejected, `fail` pulses and no further frame is sent.
- R10: A `start` pulse while `active` is 1 is ignored. It does not restart or add a frame, and it does not add a `done`.
- R11: `done` and `fail` are single-cycle pulses, and at most one of them pulses per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Strobe: card response to the write command received |
| blk_len | input | LEN_W | Block length in bytes, sampled with start |
| byte_addr | output | LEN_W | Index of the payload byte being read |
| byte_data | input | 8 | Buffer byte at byte_addr, same cycle |
| dat_out | output | 1 | Value driven on the data line |
| dat_oe | output | 1 | Drive enable for the data line |
| dat_in | input | 1 | Data line level as seen at the pin |
| active | output | 1 | A request is in progress |
| done | output | 1 | Pulse: block accepted and card no longer busy |
| fail | output | 1 | Pulse: retries exhausted or token timeout |

## Verification
The frame is driven with a mixed byte pattern, an all-zero/all-one/alternating pattern, a lone top-bit byte and an empty block. These tell byte order apart from bit order, and payload bits apart from CRC bits, and the empty block isolates the CRC seed. The card model's replies separate the outcomes. It sends an accepting token, a rejecting token, a token with the right code and a broken end bit, repeated rejections past the retry limit, and silence. Busy holds of several lengths show whether completion waits for the line to rise. A stray start pulse in the middle of a frame shows whether a running request can be disturbed.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_SBIT,
        ST_DATA,
        ST_CRC,
        ST_EBIT,
        ST_TOKEN,
        ST_BUSY
    } wr_state_e;

    typedef enum logic [1:0] {
        TK_IDLE,
        TK_HUNT,
        TK_BITS,
        TK_END
    } tok_state_e;

    typedef struct packed {
        logic       valid;
        logic [2:0] code;
        logic       framed;
    } tok_result_t;

    localparam logic [2:0]  TOKEN_ACCEPT = 3'b010;
    localparam logic [15:0] CRC_POLY     = 16'h1021;

    function automatic logic [15:0] crc_next(input logic [15:0] cur, input logic din);
        logic fb;
        fb = cur[15] ^ din;
        return {cur[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction

    function automatic logic token_good(input tok_result_t t);
        return t.framed && (t.code == TOKEN_ACCEPT);
    endfunction

endpackage

// File: rtl/sbw_crc16.sv
module sbw_crc16
    import sbw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic feed,
    input  logic shift,
    input  logic bit_in,
    output logic msb
);

    logic [15:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_q <= '0;
        end else if (feed) begin
            crc_q <= crc_next(crc_q, bit_in);
        end else if (shift) begin
            crc_q <= {crc_q[14:0], 1'b0};
        end
    end

    assign msb = crc_q[15];

    // R4: the register either absorbs payload or empties out, never both
    assert_crc_mode_R4: assert property (@(posedge clk) disable iff (rst)
        !(feed && shift));

    // R4: a cleared register starts from zero
    assert_crc_seed_R4: assert property (@(posedge clk) disable iff (rst)
        $past(clear) |-> (msb == 1'b0));

endmodule

// File: rtl/sbw_tok_rx.sv
module sbw_tok_rx
    import sbw_pkg::*;
#(
    parameter int TIMEOUT = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        arm,
    input  logic        line_in,
    output tok_result_t result,
    output logic        timeout
);

    localparam int TMO_W = $clog2(TIMEOUT + 1);

    tok_state_e       ts_q;
    logic [TMO_W-1:0] wait_q;
    logic [1:0]       nbit_q;
    logic [2:0]       sh_q;
    tok_result_t      res_q;
    logic             tmo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_q   <= TK_IDLE;
            wait_q <= '0;
            nbit_q <= '0;
            sh_q   <= '0;
            res_q  <= '0;
            tmo_q  <= 1'b0;
        end else begin
            res_q.valid <= 1'b0;
            tmo_q       <= 1'b0;
            case (ts_q)
                TK_IDLE: begin
                    if (arm) begin
                        ts_q   <= TK_HUNT;
                        wait_q <= '0;
                    end
                end
                TK_HUNT: begin
                    if (!line_in) begin
                        ts_q   <= TK_BITS;
                        nbit_q <= '0;
                    end else if (wait_q == TMO_W'(TIMEOUT - 1)) begin
                        tmo_q <= 1'b1;
                        ts_q  <= TK_IDLE;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                TK_BITS: begin
                    sh_q <= {sh_q[1:0], line_in};
                    if (nbit_q == 2'd2) begin
                        ts_q <= TK_END;
                    end else begin
                        nbit_q <= nbit_q + 1'b1;
                    end
                end
                TK_END: begin
                    res_q.valid  <= 1'b1;
                    res_q.code   <= sh_q;
                    res_q.framed <= line_in;
                    ts_q         <= TK_IDLE;
                end
                default: ts_q <= TK_IDLE;
            endcase
        end
    end

    assign result  = res_q;
    assign timeout = tmo_q;

    // R5: a timeout and a received token never coincide
    assert_tok_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(result.valid && timeout));

    // R5: a timeout is only declared after the line was seen high
    assert_tok_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        timeout |-> $past(line_in));

endmodule

// File: rtl/serial_block_writer.sv
module serial_block_writer
    import sbw_pkg::*;
#(
    parameter int LEN_W       = 10,
    parameter int N_WR        = 2,
    parameter int TOK_TIMEOUT = 64,
    parameter int MAX_RETRY   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] blk_len,
    output logic [LEN_W-1:0] byte_addr,
    input  logic [7:0]       byte_data,
    output logic             dat_out,
    output logic             dat_oe,
    input  logic             dat_in,
    output logic             active,
    output logic             done,
    output logic             fail
);

    localparam int GAP_W = $clog2(N_WR + 1);
    localparam int TRY_W = $clog2(MAX_RETRY + 2);

    wr_state_e        st_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] byte_q;
    logic [2:0]       bit_q;
    logic [3:0]       ccnt_q;
    logic [GAP_W-1:0] gap_q;
    logic [TRY_W-1:0] try_q;
    logic             good_q;
    logic             done_q;
    logic             fail_q;

    tok_result_t tok;
    logic        tok_tmo;
    logic        tok_arm;
    logic        crc_clear;
    logic        crc_feed;
    logic        crc_shift;
    logic        crc_msb;
    logic        payload_bit;

    assign payload_bit = byte_data[3'd7 - bit_q];
    assign crc_clear   = (st_q == ST_GAP);
    assign crc_feed    = (st_q == ST_DATA);
    assign crc_shift   = (st_q == ST_CRC);
    assign tok_arm     = (st_q == ST_EBIT);

    sbw_crc16 u_crc (
        .clk    (clk),
        .rst    (rst),
        .clear  (crc_clear),
        .feed   (crc_feed),
        .shift  (crc_shift),
        .bit_in (payload_bit),
        .msb    (crc_msb)
    );

    sbw_tok_rx #(.TIMEOUT(TOK_TIMEOUT)) u_tok (
        .clk     (clk),
        .rst     (rst),
        .arm     (tok_arm),
        .line_in (dat_in),
        .result  (tok),
        .timeout (tok_tmo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            len_q  <= '0;
            byte_q <= '0;
            bit_q  <= '0;
            ccnt_q <= '0;
            gap_q  <= '0;
            try_q  <= '0;
            good_q <= 1'b0;
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        len_q <= blk_len;
                        try_q <= '0;
                        gap_q <= '0;
                        st_q  <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_q == GAP_W'(N_WR - 1)) begin
                        st_q <= ST_SBIT;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                ST_SBIT: begin
                    byte_q <= '0;
                    bit_q  <= '0;
                    ccnt_q <= '0;
                    st_q   <= (len_q == '0) ? ST_CRC : ST_DATA;
                end
                ST_DATA: begin
                    bit_q <= bit_q + 1'b1;
                    if (bit_q == 3'd7) begin
                        if (byte_q == len_q - 1'b1) begin
                            st_q <= ST_CRC;
                        end else begin
                            byte_q <= byte_q + 1'b1;
                        end
                    end
                end
                ST_CRC: begin
                    ccnt_q <= ccnt_q + 1'b1;
                    if (ccnt_q == 4'd15) begin
                        st_q <= ST_EBIT;
                    end
                end
                ST_EBIT: begin
                    st_q <= ST_TOKEN;
                end
                ST_TOKEN: begin
                    if (tok_tmo) begin
                        fail_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end else if (tok.valid) begin
                        good_q <= token_good(tok);
                        st_q   <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (dat_in) begin
                        if (good_q) begin
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else if (try_q == TRY_W'(MAX_RETRY)) begin
                            fail_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else begin
                            try_q <= try_q + 1'b1;
                            gap_q <= '0;
                            st_q  <= ST_GAP;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (st_q)
            ST_SBIT: dat_out = 1'b0;
            ST_DATA: dat_out = payload_bit;
            ST_CRC:  dat_out = crc_msb;
            default: dat_out = 1'b1;
        endcase
    end

    assign dat_oe    = (st_q == ST_SBIT) || (st_q == ST_DATA) ||
                       (st_q == ST_CRC)  || (st_q == ST_EBIT);
    assign byte_addr = byte_q;
    assign active    = (st_q != ST_IDLE);
    assign done      = done_q;
    assign fail      = fail_q;

    // R2: every frame opens with a low start bit
    assert_start_bit_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(dat_oe) |-> !dat_out);

    // R4: every frame closes with a high end bit before release
    assert_end_bit_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(dat_oe) |-> $past(dat_out));

    // R8: completion is only reported once the card has let the line go high
    assert_done_line_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(dat_in));

    // R11: completion and failure are exclusive single-cycle pulses
    assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(done && fail));
    assert_done_width_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_fail_width_R11: assert property (@(posedge clk) disable iff (rst)
        fail |=> !fail);

    // R9: the retry count never passes its limit
    assert_retry_cap_R9: assert property (@(posedge clk) disable iff (rst)
        (try_q <= TRY_W'(MAX_RETRY)));

endmodule

// File: tb/test_serial_block_writer.sv
module test_serial_block_writer;

    localparam int LEN_W = 10;
    localparam int N_WR  = 2;
    localparam int TOKTO = 64;
    localparam int MAXR  = 2;

    logic             clk = 1'b0;
    logic             rst;
    logic             start;
    logic [LEN_W-1:0] blk_len;
    logic [LEN_W-1:0] byte_addr;
    logic [7:0]       byte_data;
    logic             dat_out;
    logic             dat_oe;
    logic             dat_in;
    logic             active;
    logic             done;
    logic             fail;
    logic             card_oe;
    logic             card_out;

    logic [7:0] mem [0:255];
    logic       got [0:4095];
    logic       expb [0:4095];
    int         gotn;
    int         expn;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    assign byte_data = mem[byte_addr[7:0]];
    assign dat_in    = dat_oe ? dat_out : (card_oe ? card_out : 1'b1);

    serial_block_writer #(
        .LEN_W(LEN_W), .N_WR(N_WR), .TOK_TIMEOUT(TOKTO), .MAX_RETRY(MAXR)
    ) i_serial_block_writer (
        .clk(clk), .rst(rst), .start(start), .blk_len(blk_len),
        .byte_addr(byte_addr), .byte_data(byte_data),
        .dat_out(dat_out), .dat_oe(dat_oe), .dat_in(dat_in),
        .active(active), .done(done), .fail(fail)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (dat_oe && card_oe) chk(1'b0, "R4", "line contention", 1, 0);
        if (cyc > 150000) begin
            chk(1'b0, "R1", "watchdog expired", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic build_exp(input int len);
        logic [15:0] c;
        logic        b;
        logic        fb;
        c = 16'h0000;
        expn = 0;
        expb[expn] = 1'b0; expn++;
        for (int i = 0; i < len; i++) begin
            for (int k = 7; k >= 0; k--) begin
                b = mem[i][k];
                expb[expn] = b; expn++;
                fb = c[15] ^ b;
                c = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end
        end
        for (int k = 15; k >= 0; k--) begin
            expb[expn] = c[k]; expn++;
        end
        expb[expn] = 1'b1; expn++;
    endtask

    task automatic pulse_start(input int len);
        @(negedge clk);
        blk_len = LEN_W'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Waits for the engine to drive, then records the frame bit by bit.
    task automatic grab_frame(input int poke_at, output int gap, output bit seen);
        gap  = 0;
        seen = 1'b0;
        gotn = 0;
        while (!dat_oe && gap < 400) begin
            gap++;
            @(negedge clk);
        end
        if (!dat_oe) return;
        seen = 1'b1;
        while (dat_oe && gotn < 4096) begin
            got[gotn] = dat_out;
            start = (gotn == poke_at);
            gotn++;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic cmp_frame(input string req);
        int mism;
        mism = -1;
        chk(gotn == expn, req, "frame length", gotn, expn);
        for (int i = 0; i < expn && i < gotn; i++) begin
            if (mism < 0 && got[i] !== expb[i]) mism = i;
        end
        chk(mism < 0, req, "first bad frame bit index", mism, -1);
    endtask

    // Card side: called on the negedge where the engine has just released.
    task automatic card_reply(input logic [2:0] code, input logic endb,
                              input int dly, input int busy);
        bit quiet;
        quiet = 1'b1;
        repeat (dly) @(negedge clk);
        card_oe = 1'b1;
        card_out = 1'b0;     @(negedge clk);
        card_out = code[2];  @(negedge clk);
        card_out = code[1];  @(negedge clk);
        card_out = code[0];  @(negedge clk);
        card_out = endb;     @(negedge clk);
        card_out = 1'b0;
        for (int i = 0; i < busy; i++) begin
            if (done || fail || dat_oe) quiet = 1'b0;
            @(negedge clk);
        end
        card_oe = 1'b0;
        chk(quiet, "R8", "engine stayed quiet while card busy", 0, 1);
    endtask

    task automatic watch(input int cycles, output int dn, output int fl, output int oe);
        dn = 0; fl = 0; oe = 0;
        for (int i = 0; i < cycles; i++) begin
            if (done) dn++;
            if (fail) fl++;
            if (dat_oe) oe++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; blk_len = '0; card_oe = 1'b0; card_out = 1'b1;
        repeat (3) @(negedge clk);
        chk(!dat_oe && !active && !done && !fail, "R1", "outputs in reset",
            int'({dat_oe, active, done, fail}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!dat_oe && !active && !done && !fail && dat_in, "R1", "outputs after reset",
            int'({dat_oe, active, done, fail}), 0);
    endtask

    task automatic t_basic();
        int gap; bit seen; int dn; int fl; int oe;
        for (int i = 0; i < 4; i++) mem[i] = 8'(i * 37 + 5);
        build_exp(4);
        pulse_start(4);
        grab_frame(-1, gap, seen);
        chk(seen, "R2", "frame appeared", int'(seen), 1);
        chk(gap == N_WR, "R2", "idle clocks before start bit", gap, N_WR);
        cmp_frame("R3");
        card_reply(3'b010, 1'b1, 2, 6);
        watch(6, dn, fl, oe);
        chk(dn == 1, "R6", "single done pulse after accept", dn, 1);
        chk(fl == 0 && oe == 0, "R11", "no fail or resend after accept", fl + oe, 0);
        chk(!active, "R6", "idle after done", int'(active), 0);
    endtask

    task automatic t_patterns();
        int gap; bit seen; int dn; int fl; int oe;
        mem[0] = 8'h00; mem[1] = 8'hFF; mem[2] = 8'hA5;
        build_exp(3);
        pulse_start(3);
        grab_frame(-1, gap, seen);
        cmp_frame("R4");
        card_reply(3'b010, 1'b1, 0, 0);
        watch(6, dn, fl, oe);
        chk(dn == 1 && fl == 0, "R8", "done with zero busy", dn, 1);
        mem[0] = 8'h80;
        build_exp(1);
        pulse_start(1);
        grab_frame(-1, gap, seen);
        cmp_frame("R3");
        card_reply(3'b010, 1'b1, 5, 3);
        watch(6, dn, fl, oe);
        chk(dn == 1, "R3", "done for one-byte block", dn, 1);
    endtask

    task automatic t_zero();
        int gap; bit seen; int dn; int fl; int oe;
        build_exp(0);
        pulse_start(0);
        grab_frame(-1, gap, seen);
        chk(gotn == 18, "R3", "empty block frame length", gotn, 18);
        cmp_frame("R4");
        card_reply(3'b010, 1'b1, 1, 2);
        watch(6, dn, fl, oe);
        chk(dn == 1, "R3", "done for empty block", dn, 1);
    endtask

    task automatic t_retry(input logic [2:0] bad_code, input logic bad_end);
        int gap; bit seen; int dn; int fl; int oe;
        for (int i = 0; i < 5; i++) mem[i] = 8'(8'hC3 ^ (i * 17));
        build_exp(5);
        pulse_start(5);
        grab_frame(-1, gap, seen);
        cmp_frame("R7");
        card_reply(bad_code, bad_end, 1, 4);
        grab_frame(-1, gap, seen);
        chk(seen, "R7", "retransmission started", int'(seen), 1);
        cmp_frame("R7");
        card_reply(3'b010, 1'b1, 1, 1);
        watch(6, dn, fl, oe);
        chk(dn == 1 && fl == 0, "R7", "done after retransmission", dn, 1);
    endtask

    task automatic t_exhaust();
        int gap; bit seen; int dn; int fl; int oe; int frames;
        for (int i = 0; i < 2; i++) mem[i] = 8'(8'h5A + i);
        build_exp(2);
        frames = 0;
        pulse_start(2);
        for (int a = 0; a <= MAXR; a++) begin
            grab_frame(-1, gap, seen);
            if (seen) frames++;
            cmp_frame("R9");
            card_reply(3'b101, 1'b1, 1, 2);
        end
        watch(60, dn, fl, oe);
        chk(frames == MAXR + 1, "R9", "frames sent", frames, MAXR + 1);
        chk(fl == 1 && dn == 0, "R9", "fail pulse after limit", fl, 1);
        chk(oe == 0, "R9", "no frame after limit", oe, 0);
    endtask

    task automatic t_timeout();
        int gap; bit seen; int dn; int fl; int oe;
        mem[0] = 8'h3C;
        build_exp(1);
        pulse_start(1);
        grab_frame(-1, gap, seen);
        cmp_frame("R5");
        watch(TOKTO - 4, dn, fl, oe);
        chk(fl == 0, "R5", "no fail before timeout", fl, 0);
        watch(40, dn, fl, oe);
        chk(fl == 1 && dn == 0, "R5", "fail on missing token", fl, 1);
        chk(oe == 0, "R5", "no resend on timeout", oe, 0);
    endtask

    task automatic t_ignore();
        int gap; bit seen; int dn; int fl; int oe;
        for (int i = 0; i < 4; i++) mem[i] = 8'(8'h91 + i * 3);
        build_exp(4);
        pulse_start(4);
        grab_frame(10, gap, seen);
        cmp_frame("R10");
        card_reply(3'b010, 1'b1, 1, 3);
        watch(50, dn, fl, oe);
        chk(dn == 1, "R10", "one done despite extra start", dn, 1);
        chk(oe == 0, "R10", "no extra frame from extra start", oe, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_patterns();
        t_zero();
        t_retry(3'b101, 1'b1);
        t_retry(3'b010, 1'b0);
        t_exhaust();
        t_timeout();
        t_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule